// File: doc/BRIEF.md
# Page-Buffered Write Collector and Address Sequencer

This block sits behind a two-wire serial memory front end and works at byte level. The front end turns bus traffic into single-cycle events: a write header accepted (`hdr_wr`), a byte received (`rx_vld`/`rx_byte`), a stop condition (`bus_stop`) and a request for the next read byte (`tx_req`). The block holds the internal address counter. It splits the two address bytes into a page index and a byte offset. It gathers write data in a page buffer that has a per-byte valid mask. After a stop, it copies the marked bytes into an internal byte-array model, one buffer slot per cycle. An outside protection decision arrives on `wr_allow`.

The sequencer runs five states. The transitions are:
- IDLE goes to ADDR_HI on `hdr_wr`.
- ADDR_HI goes to ADDR_LO on the first byte.
- ADDR_LO goes to DATA on the second byte, which loads the counter.
- DATA goes to COMMIT on a stop, if at least one byte was accepted.
- ADDR_HI, ADDR_LO and DATA go back to IDLE on a stop without data. A read request from any state other than COMMIT also ends in IDLE, after one array read.
- COMMIT goes to IDLE after the last buffer slot.

Between events the state holds. Events are ranked read request, then stop, then header, then byte. The array width `ADDR_W` is a parameter. Its default of 10 gives a 1 KB model, and a value of 14 gives the 16 KB, 256-page array.

Top module: `pgwr_seq`

## Requirements
- R1: The first address byte after a header is the high byte and the second is the low byte. The counter takes bits [ADDR_W-1:0] of {high, low}, and higher bits are ignored. Counter bits [ADDR_W-1:6] are the page and bits [5:0] are the offset.
- R2: Each accepted data byte goes to the current offset, and then the offset increments modulo 64 with the page unchanged. More than 64 bytes overwrite earlier slots, and nothing spills into the next page.
- R3: A commit changes only the array bytes whose slots were written in that burst. Other bytes of the page keep their contents.
- R4: A stop in DATA with at least one accepted byte raises `busy` on the next cycle for exactly 64 cycles. While `busy` is high, every input event is ignored, and a read request produces no `rx`/`tx` response.
- R5: A read request outside COMMIT gives `tx_vld` high on the next cycle. `tx_data` then holds the array byte at the counter, and the counter advances by one.
- R6: A header, two address bytes and then a read request return the byte at the loaded address.
- R7: Successive reads advance through the full address and wrap from the last array byte to address 0.
- R8: After reset every array byte reads FFh, and `busy` and `tx_vld` are low.
- R9: A stop after the address bytes with no accepted data byte only loads the counter, and `busy` stays low.
- R10: With `wr_allow` low, a data byte is not buffered and does not move the offset. A burst with no accepted byte starts no commit.
- R11: After a burst commits, the counter points at the slot after the last written one, wrapped within the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_wr | input | 1 | Write header accepted (pulse) |
| rx_vld | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| bus_stop | input | 1 | Stop condition seen (pulse) |
| tx_req | input | 1 | Next read byte wanted (pulse) |
| wr_allow | input | 1 | Protection decision: data bytes may be buffered |
| tx_vld | output | 1 | Read byte valid (one cycle) |
| tx_data | output | 8 | Read byte |
| busy | output | 1 | Commit in progress |

## Verification
The assertions assume the front end raises at most one event per cycle and sends event pulses only one cycle wide. They also assume `wr_allow` is steady for the cycle of a byte. Where more than one event is raised in a cycle, only the ranked one is taken to act. The bench drives every event as a one-cycle pulse on the falling edge, one at a time, and holds `wr_allow` well away from byte strobes. During a commit it issues a read request on purpose, to test the ignore rule.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_DATA,
        ST_COMMIT
    } seq_state_e;
endpackage

// File: rtl/pgwr_pbuf.sv
module pgwr_pbuf #(
    parameter int PAGE_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        wr,
    input  logic [PAGE_W-1:0]           wr_off,
    input  logic [pgwr_pkg::BYTE_W-1:0] wr_data,
    input  logic [PAGE_W-1:0]           rd_off,
    output logic [pgwr_pkg::BYTE_W-1:0] rd_data,
    output logic                        rd_mark
);
    localparam int SLOTS = 1 << PAGE_W;

    logic [pgwr_pkg::BYTE_W-1:0] slot_q [SLOTS];
    logic [SLOTS-1:0]            mark_q;

    // One storage cell and one valid bit per slot.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '1;
                mark_q[g] <= 1'b0;
            end else if (clr) begin
                mark_q[g] <= 1'b0;
            end else if (wr && wr_off == PAGE_W'(g)) begin
                slot_q[g] <= wr_data;
                mark_q[g] <= 1'b1;
            end
        end
    end

    assign rd_data = slot_q[rd_off];
    assign rd_mark = mark_q[rd_off];
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array #(
    parameter int ADDR_W = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           waddr,
    input  logic [pgwr_pkg::BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]           raddr,
    output logic [pgwr_pkg::BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [pgwr_pkg::BYTE_W-1:0] cell_q [DEPTH];

    // Erased state after reset is all ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_wr,
    input  logic              rx_vld,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              bus_stop,
    input  logic              tx_req,
    input  logic              wr_allow,
    output logic              tx_vld,
    output logic [BYTE_W-1:0] tx_data,
    output logic              busy
);
    localparam int HI_W  = ADDR_W - BYTE_W;
    localparam int PG_IW = ADDR_W - PAGE_W;
    localparam logic [PAGE_W-1:0] LAST_SLOT = '1;

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [HI_W-1:0]   hi_q;
    logic              any_q;
    logic [PAGE_W-1:0] cidx_q;
    logic [BYTE_W-1:0] tx_data_q;
    logic              tx_vld_q;

    logic ev_rd, ev_stop, ev_hdr, ev_byte, in_commit;
    logic acc_byte, ld_addr, buf_clr, arr_we, commit_done;
    logic [BYTE_W-1:0] pb_rdata, arr_rdata;
    logic              pb_mark;

    // Ranked event decode; a commit masks every event.
    always_comb begin
        in_commit = (state_q == ST_COMMIT);
        ev_rd     = tx_req && !in_commit;
        ev_stop   = bus_stop && !in_commit && !ev_rd;
        ev_hdr    = hdr_wr && !in_commit && !ev_rd && !ev_stop;
        ev_byte   = rx_vld && !in_commit && !ev_rd && !ev_stop && !ev_hdr;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ev_hdr) state_d = ST_ADDR_HI;
            end
            ST_ADDR_HI: begin
                if (ev_rd || ev_stop) state_d = ST_IDLE;
                else if (ev_byte)     state_d = ST_ADDR_LO;
            end
            ST_ADDR_LO: begin
                if (ev_rd || ev_stop) state_d = ST_IDLE;
                else if (ev_hdr)      state_d = ST_ADDR_HI;
                else if (ev_byte)     state_d = ST_DATA;
            end
            ST_DATA: begin
                if (ev_rd)              state_d = ST_IDLE;
                else if (ev_stop)       state_d = any_q ? ST_COMMIT : ST_IDLE;
                else if (ev_hdr)        state_d = ST_ADDR_HI;
            end
            ST_COMMIT: begin
                if (cidx_q == LAST_SLOT) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (state_q == ST_IDLE && ev_hdr) state_d = ST_ADDR_HI;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output and control decode.
    always_comb begin
        acc_byte    = ev_byte && (state_q == ST_DATA) && wr_allow;
        ld_addr     = ev_byte && (state_q == ST_ADDR_LO);
        commit_done = in_commit && (cidx_q == LAST_SLOT);
        buf_clr     = ev_hdr || ev_rd || commit_done;
        arr_we      = in_commit && pb_mark;
        busy        = in_commit;
    end

    // Counter, address capture, burst flag, commit index, read data.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            hi_q      <= '0;
            any_q     <= 1'b0;
            cidx_q    <= '0;
            tx_data_q <= '0;
            tx_vld_q  <= 1'b0;
        end else begin
            tx_vld_q <= ev_rd;
            if (ev_rd) begin
                tx_data_q <= arr_rdata;
                addr_q    <= addr_q + 1'b1;
            end
            if (ev_hdr) any_q <= 1'b0;
            if (ev_byte && state_q == ST_ADDR_HI) hi_q <= rx_byte[HI_W-1:0];
            if (ld_addr) addr_q <= {hi_q, rx_byte};
            if (acc_byte) begin
                addr_q <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
                any_q  <= 1'b1;
            end
            if (in_commit) cidx_q <= cidx_q + 1'b1;
            else           cidx_q <= '0;
        end
    end

    assign tx_vld  = tx_vld_q;
    assign tx_data = tx_data_q;

    pgwr_pbuf #(.PAGE_W(PAGE_W)) u_pbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr      (acc_byte),
        .wr_off  (addr_q[PAGE_W-1:0]),
        .wr_data (rx_byte),
        .rd_off  (cidx_q),
        .rd_data (pb_rdata),
        .rd_mark (pb_mark)
    );

    pgwr_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr ({addr_q[ADDR_W-1:PAGE_W], cidx_q}),
        .wdata (pb_rdata),
        .raddr (addr_q),
        .rdata (arr_rdata)
    );

    logic [PG_IW-1:0] page_idx;
    assign page_idx = addr_q[ADDR_W-1:PAGE_W];
    logic unused_page;
    assign unused_page = ^page_idx;
endmodule

// File: rtl/pgwr_seq_chk.sv
module pgwr_seq_chk
    import pgwr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hdr_wr,
    input logic              rx_vld,
    input logic              bus_stop,
    input logic              tx_req,
    input logic              wr_allow,
    input logic              tx_vld,
    input logic              busy,
    input seq_state_e        st,
    input logic [ADDR_W-1:0] ctr
);
    localparam int SLOTS = 1 << PAGE_W;

    logic [PAGE_W:0] bcnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    logic only_byte;
    assign only_byte = rx_vld && !hdr_wr && !bus_stop && !tx_req;

    // R4: busy lasts exactly one page of cycles
    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> bcnt == (PAGE_W+1)'(SLOTS));
    p_busy_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> bcnt < (PAGE_W+1)'(SLOTS));
    p_busy_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_stop));
    p_ignore_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctr) && !tx_vld);
    // R5: read response and counter step
    p_read_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !busy) |=> tx_vld && ctr == $past(ctr) + 1'b1);
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_req && !busy) |=> !tx_vld);
    // R2: accepted data byte steps offset inside the page
    p_offset_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && only_byte && wr_allow) |=>
            ctr[ADDR_W-1:PAGE_W] == $past(ctr[ADDR_W-1:PAGE_W]) &&
            ctr[PAGE_W-1:0] == $past(ctr[PAGE_W-1:0]) + 1'b1);
    // R10: refused byte leaves the counter alone
    p_refused_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && only_byte && !wr_allow) |=> $stable(ctr));
endmodule

bind pgwr_seq pgwr_seq_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hdr_wr   (hdr_wr),
    .rx_vld   (rx_vld),
    .bus_stop (bus_stop),
    .tx_req   (tx_req),
    .wr_allow (wr_allow),
    .tx_vld   (tx_vld),
    .busy     (busy),
    .st       (state_q),
    .ctr      (addr_q)
);

// File: tb/pgwr_seq_test.sv
`timescale 1ns/1ps
module pgwr_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hdr_wr = 1'b0, rx_vld = 1'b0, bus_stop = 1'b0, tx_req = 1'b0;
    logic       wr_allow = 1'b1;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_vld, busy;
    logic [7:0] tx_data;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    pgwr_seq uut (
        .clk(clk), .rst_n(rst_n), .hdr_wr(hdr_wr), .rx_vld(rx_vld),
        .rx_byte(rx_byte), .bus_stop(bus_stop), .tx_req(tx_req),
        .wr_allow(wr_allow), .tx_vld(tx_vld), .tx_data(tx_data), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_hdr();
        hdr_wr = 1'b1; @(negedge clk); hdr_wr = 1'b0;
    endtask

    task automatic pulse_byte(input logic [7:0] b);
        rx_byte = b; rx_vld = 1'b1; @(negedge clk); rx_vld = 1'b0;
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
        pulse_hdr(); pulse_byte(hi); pulse_byte(lo);
    endtask

    // Stop, then wait out any commit; returns busy cycles seen.
    task automatic pulse_stop(output int cycles);
        bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
        cycles = 0;
        while (busy && cycles < 1000) begin
            cycles++; @(negedge clk);
        end
    endtask

    task automatic read_one(input string tag, output logic [7:0] d);
        tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
        chk({tag, " tx_vld"}, int'(tx_vld), 1);
        d = tx_data;
    endtask

    task automatic read_at(input logic [7:0] hi, input logic [7:0] lo,
                           input string tag, output logic [7:0] d);
        set_addr(hi, lo);
        read_one(tag, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R8 busy after reset", int'(busy), 0);
        chk("R8 tx_vld after reset", int'(tx_vld), 0);
        read_at(8'h02, 8'h77, "R6", d);
        chk("R8 erased byte", int'(d), 8'hFF);
    endtask

    task automatic t_byte_write_r1();
        logic [7:0] d; int n;
        set_addr(8'hF1, 8'h23);
        pulse_byte(8'hA5);
        pulse_stop(n);
        chk("R4 busy length", n, 64);
        read_at(8'h01, 8'h23, "R1", d);
        chk("R1 high bits ignored, R6 selective read", int'(d), 8'hA5);
        read_one("R5", d);
        chk("R5 next byte erased", int'(d), 8'hFF);
    endtask

    task automatic t_page_wrap_r2();
        logic [7:0] d; int n;
        set_addr(8'h01, 8'h7E);
        for (int k = 0; k < 66; k++) pulse_byte(8'(k));
        pulse_stop(n);
        chk("R4 busy length page", n, 64);
        read_one("R11", d);
        chk("R11 counter after wrap points at page start", int'(d), 2);
        set_addr(8'h01, 8'h40);
        for (int o = 0; o < 64; o++) begin
            read_one("R2", d);
            chk($sformatf("R2 slot %0d", o), int'(d), o + 2);
        end
        read_one("R2", d);
        chk("R2 no spill to next page", int'(d), 8'hFF);
    endtask

    task automatic t_partial_r3();
        logic [7:0] d; int n;
        set_addr(8'h00, 8'hD0);
        pulse_byte(8'h3C);
        pulse_stop(n);
        set_addr(8'h00, 8'hD1);
        pulse_byte(8'h11); pulse_byte(8'h22);
        pulse_stop(n);
        read_at(8'h00, 8'hD0, "R3", d);
        chk("R3 untouched slot kept", int'(d), 8'h3C);
        read_one("R3", d); chk("R3 written slot 1", int'(d), 8'h11);
        read_one("R3", d); chk("R3 written slot 2", int'(d), 8'h22);
        read_one("R3", d); chk("R3 untouched slot erased", int'(d), 8'hFF);
    endtask

    task automatic t_addr_only_r9();
        logic [7:0] d; int n;
        set_addr(8'h00, 8'hD1);
        pulse_stop(n);
        chk("R9 no commit", n, 0);
        read_one("R9", d);
        chk("R9 counter loaded", int'(d), 8'h11);
    endtask

    task automatic t_refused_r10();
        logic [7:0] d; int n;
        set_addr(8'h02, 8'h00);
        wr_allow = 1'b0;
        pulse_byte(8'h55);
        wr_allow = 1'b1;
        pulse_stop(n);
        chk("R10 no commit when refused", n, 0);
        read_one("R10", d);
        chk("R10 offset not advanced, byte not stored", int'(d), 8'hFF);
    endtask

    task automatic t_seq_wrap_r7();
        logic [7:0] d; int n;
        set_addr(8'h03, 8'hFF);
        pulse_byte(8'h5A);
        pulse_stop(n);
        read_at(8'h03, 8'hFF, "R7", d);
        chk("R7 last byte", int'(d), 8'h5A);
        read_one("R7", d);
        chk("R7 wrap to address 0", int'(d), 8'hFF);
    endtask

    task automatic t_busy_ignore_r4();
        logic [7:0] d; int n;
        set_addr(8'h02, 8'h80);
        pulse_byte(8'h66);
        bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
        chk("R4 busy after stop", int'(busy), 1);
        tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
        chk("R4 read ignored while busy", int'(tx_vld), 0);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        read_one("R4", d);
        chk("R4 counter unmoved by ignored read (R11)", int'(d), 8'hFF);
        read_at(8'h02, 8'h80, "R4", d);
        chk("R4 committed byte", int'(d), 8'h66);
    endtask

    initial begin
        #(200_000 * 10);
        mismatched++;
        compared++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_write_r1();
        t_page_wrap_r2();
        t_partial_r3();
        t_addr_only_r9();
        t_refused_r10();
        t_seq_wrap_r7();
        t_busy_ignore_r4();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule